// File: doc/BRIEF.md
# Page-write memory sequencer

This block models the device side of a byte-wide nonvolatile memory that is written a page at a time. A host drives chip select, output enable, write enable, an address and a data byte, all low-active and asynchronous in spirit. The block samples them with a fast system clock. Reads return array contents through a registered data path with its own output-enable flag. Writes are collected into a page buffer and committed to the array by an internally timed cycle.

A page write follows a fixed order. An optional three-byte unlock command comes first; once it has been seen, it becomes mandatory for every later page. One or more byte loads then fill the page buffer. The window stays open while the host keeps loading bytes, and it closes after a programmable stretch of inactivity. Closing it starts the internal write, which lasts a programmable number of clock cycles. While it runs, reads return a polling status word instead of array data. The array size, the page size and both timer limits are parameters. The microsecond and millisecond intervals are expressed in clock cycles.

Top module: `pgw_mem_seq`

## Requirements
- R1: `dq_oe` is 1 only while `cs_n` and `oe_n` are both low, four clock edges after the pins change. Otherwise `dq_oe` is 0 and `dq_out` is 00h.
- R2: The unlock command is three strobes in this order: data AAh at address 5555h, data 55h at address 2AAAh, then data A0h at address 5555h. Addresses are compared on the low `ADDR_W` bits. A byte that breaks the order is discarded, and recognition restarts from the first step.
- R3: A write strobe is the interval in which `cs_n` and `we_n` are both low. The address is taken when the strobe begins, and the data byte when the strobe ends.
- R4: The load window stays open while each new strobe begins fewer than `TBLCO` idle cycles after the previous one ended. `TBLCO` idle cycles close it. If no byte was loaded, the block returns to idle without an internal write.
- R5: The low `PAGE_W` address bits select the byte within the page. The page that is written is taken from the high bits of the last byte loaded. Loading the same byte position again replaces its data.
- R6: The internal write lasts exactly `TWC` cycles, and strobes during it have no effect. When it completes, every byte of the page holds its loaded value, and positions not loaded hold FFh.
- R7: After reset the device is unprotected. In this state a byte that is not the first unlock step opens the load window directly and is loaded.
- R8: After the first complete unlock command, protection stays on. With protection on, a byte load with no unlock command in front of it leaves the array unchanged.
- R9: During the internal write, a read returns bit 7 as the inverse of bit 7 of the last loaded byte. Bit 6 toggles at the start of each read, and its first value is 1. Bits 5..0 read 0. After completion, reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| oe_n | input | 1 | Output enable, low active |
| we_n | input | 1 | Write enable, low active |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data driven by the host |
| dq_out | output | 8 | Data returned by the block |
| dq_oe | output | 1 | High when `dq_out` should drive the shared bus |

## Verification
The hardest state to reach from the ports is a read that lands inside the internal write. Reaching it needs an unlock command, a load, and a wait long enough for the inactivity timer to expire but short enough that the timed write is still running. The bench uses small timer parameters and counts idle cycles after the last strobe so that two back-to-back reads fall inside that window. A second hard case is a load window held open by a gap just under the limit. With protection on, a window that closed too early turns the second byte into an ignored load, and that shows up as FFh in the array.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_LOAD = 2'd1, PH_COMMIT = 2'd2} phase_t;
  typedef enum logic [1:0] {RC_IDLE = 2'd0, RC_STEP1 = 2'd1, RC_STEP2 = 2'd2} unlock_t;

  localparam logic [7:0]  UNLK_D1 = 8'hAA;
  localparam logic [7:0]  UNLK_D2 = 8'h55;
  localparam logic [7:0]  UNLK_D3 = 8'hA0;
  localparam logic [16:0] UNLK_A1 = 17'h05555;
  localparam logic [16:0] UNLK_A2 = 17'h02AAA;
  localparam logic [7:0]  ERASED  = 8'hFF;
endpackage

// File: rtl/pgw_bus_sampler.sv
// Two-stage pin synchronizer with strobe edge detection.
module pgw_bus_sampler #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [ADDR_W-1:0] addr_s,
  output logic              rd_act,
  output logic              rd_start,
  output logic              wr_act,
  output logic              byte_vld,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        byte_data
);
  logic [2:0]        ctl_m, ctl_s;
  logic [ADDR_W-1:0] addr_m;
  logic [7:0]        dq_m, dq_s;
  logic              wr_prev, rd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_m  <= 3'b111;
      ctl_s  <= 3'b111;
      addr_m <= '0;
      addr_s <= '0;
      dq_m   <= '0;
      dq_s   <= '0;
    end else begin
      ctl_m  <= {cs_n, oe_n, we_n};
      ctl_s  <= ctl_m;
      addr_m <= addr;
      addr_s <= addr_m;
      dq_m   <= dq_in;
      dq_s   <= dq_m;
    end
  end

  assign wr_act   = ~ctl_s[2] & ~ctl_s[0];
  assign rd_act   = ~ctl_s[2] & ~ctl_s[1];
  assign rd_start = rd_act & ~rd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev   <= 1'b0;
      rd_prev   <= 1'b0;
      byte_vld  <= 1'b0;
      byte_addr <= '0;
      byte_data <= '0;
    end else begin
      wr_prev  <= wr_act;
      rd_prev  <= rd_act;
      byte_vld <= ~wr_act & wr_prev;
      if (wr_act & ~wr_prev) byte_addr <= addr_s;
      if (~wr_act & wr_prev) byte_data <= dq_s;
    end
  end
endmodule

// File: rtl/pgw_page_buf.sv
// Page buffer: data RAM plus a per-byte loaded mask; unloaded bytes read as erased.
module pgw_page_buf import pgw_pkg::*; #(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [7:0]        rbyte
);
  localparam int PAGE = 1 << PAGE_W;

  logic [7:0]      mem [PAGE];
  logic [PAGE-1:0] loaded;
  logic [7:0]      rdata_q;
  logic            rvld_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata_q <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= '0;
      rvld_q <= 1'b0;
    end else begin
      if (clr) loaded <= '0;
      if (we) loaded[widx] <= 1'b1;
      rvld_q <= loaded[ridx];
    end
  end

  assign rbyte = rvld_q ? rdata_q : ERASED;
endmodule

// File: rtl/pgw_array.sv
// Main storage: simple dual-port RAM with a registered read.
module pgw_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgw_ctrl.sv
// Unlock recognizer, load-window timer and timed commit sequencer.
module pgw_ctrl import pgw_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 7,
  parameter int TBLCO  = 25000,
  parameter int TWC    = 625000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_act,
  input  logic              byte_vld,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [7:0]        byte_data,
  input  logic              rd_start,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [PAGE_W-1:0] buf_widx,
  output logic [7:0]        buf_wdata,
  output logic [PAGE_W-1:0] buf_ridx,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic              busy,
  output logic              prot_en,
  output logic              poll_d7,
  output logic              tog
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;
  localparam int TB_W = $clog2(TBLCO + 1);
  localparam int TW_W = $clog2(TWC + 1);
  localparam logic [ADDR_W-1:0] A1 = UNLK_A1[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A2 = UNLK_A2[ADDR_W-1:0];

  phase_t            phase;
  unlock_t           step;
  logic [TB_W-1:0]   tmr;
  logic [TW_W-1:0]   wc;
  logic [PG_W-1:0]   pg;
  logic              loaded;
  logic              rd_issue, rd_issue_d;
  logic [PAGE_W-1:0] ridx_d;
  logic              hit1, hit2, hit3, direct_open, cmd_done, tmr_done, wc_done;

  always_comb begin
    hit1        = (byte_addr == A1) && (byte_data == UNLK_D1);
    hit2        = (byte_addr == A2) && (byte_data == UNLK_D2);
    hit3        = (byte_addr == A1) && (byte_data == UNLK_D3);
    direct_open = (phase == PH_IDLE) && (step == RC_IDLE) && !hit1 && !prot_en;
    cmd_done    = (phase == PH_IDLE) && (step == RC_STEP2) && hit3;
    buf_we      = byte_vld && ((phase == PH_LOAD) || direct_open);
    buf_clr     = byte_vld && (direct_open || cmd_done);
    buf_widx    = byte_addr[PAGE_W-1:0];
    buf_wdata   = byte_data;
    rd_issue    = (phase == PH_COMMIT) && (wc < TW_W'(PAGE));
    buf_ridx    = wc[PAGE_W-1:0];
    tmr_done    = tmr == TB_W'(TBLCO - 1);
    wc_done     = wc == TW_W'(TWC - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      step       <= RC_IDLE;
      prot_en    <= 1'b0;
      tmr        <= '0;
      wc         <= '0;
      pg         <= '0;
      loaded     <= 1'b0;
      poll_d7    <= 1'b0;
      tog        <= 1'b0;
      rd_issue_d <= 1'b0;
      ridx_d     <= '0;
    end else begin
      rd_issue_d <= rd_issue;
      ridx_d     <= buf_ridx;
      if (buf_we) begin
        pg      <= byte_addr[ADDR_W-1:PAGE_W];
        poll_d7 <= byte_data[7];
        loaded  <= 1'b1;
      end else if (buf_clr) begin
        loaded <= 1'b0;
      end
      case (phase)
        PH_IDLE: begin
          if (byte_vld) begin
            tmr <= '0;
            case (step)
              RC_IDLE: begin
                if (hit1) step <= RC_STEP1;
                else if (!prot_en) phase <= PH_LOAD;
              end
              RC_STEP1: step <= hit2 ? RC_STEP2 : RC_IDLE;
              RC_STEP2: begin
                step <= RC_IDLE;
                if (hit3) begin
                  prot_en <= 1'b1;
                  phase   <= PH_LOAD;
                end
              end
              default: step <= RC_IDLE;
            endcase
          end
        end
        PH_LOAD: begin
          if (wr_act || byte_vld) begin
            tmr <= '0;
          end else if (tmr_done) begin
            tmr <= '0;
            if (loaded) begin
              phase <= PH_COMMIT;
              wc    <= '0;
              tog   <= 1'b0;
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_COMMIT: begin
          if (rd_start) tog <= ~tog;
          if (wc_done) phase <= PH_IDLE;
          else wc <= wc + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase == PH_COMMIT);
  assign arr_we    = rd_issue_d;
  assign arr_waddr = {pg, ridx_d};
endmodule

// File: rtl/pgw_mem_seq.sv
// Top: page-write memory sequencer with registered read path.
module pgw_mem_seq #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 7,
  parameter int TBLCO  = 25000,
  parameter int TWC    = 625000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  logic [ADDR_W-1:0] addr_s, byte_addr, arr_waddr;
  logic              rd_act, rd_start, wr_act, byte_vld;
  logic [7:0]        byte_data, buf_wdata, buf_rbyte, arr_rdata;
  logic              buf_clr, buf_we, arr_we, busy, prot_en, poll_d7, tog;
  logic [PAGE_W-1:0] buf_widx, buf_ridx;
  logic [7:0]        stat_q;
  logic              stat_sel, rden_q;

  pgw_bus_sampler #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .addr_s(addr_s), .rd_act(rd_act),
    .rd_start(rd_start), .wr_act(wr_act), .byte_vld(byte_vld),
    .byte_addr(byte_addr), .byte_data(byte_data)
  );

  pgw_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TBLCO(TBLCO), .TWC(TWC)) u_ctrl (
    .clk(clk), .rst(rst), .wr_act(wr_act), .byte_vld(byte_vld),
    .byte_addr(byte_addr), .byte_data(byte_data), .rd_start(rd_start),
    .buf_clr(buf_clr), .buf_we(buf_we), .buf_widx(buf_widx),
    .buf_wdata(buf_wdata), .buf_ridx(buf_ridx), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .busy(busy), .prot_en(prot_en),
    .poll_d7(poll_d7), .tog(tog)
  );

  pgw_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .widx(buf_widx),
    .wdata(buf_wdata), .ridx(buf_ridx), .rbyte(buf_rbyte)
  );

  pgw_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(buf_rbyte),
    .raddr(addr_s), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      stat_sel <= 1'b0;
      rden_q   <= 1'b0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
    end else begin
      stat_q   <= {~poll_d7, tog, 6'b0};
      stat_sel <= busy;
      rden_q   <= rd_act;
      dq_oe    <= rden_q;
      dq_out   <= rden_q ? (stat_sel ? stat_q : arr_rdata) : 8'h00;
    end
  end
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 7,
  parameter int TWC    = 625000
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_waddr,
  input logic              prot_en
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  AST_OE_GATED: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!cs_n && !oe_n, 4)); // R1
  AST_COMMIT_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == TWC)); // R6
  AST_ARRAY_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy); // R6
  AST_ONE_PAGE: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |-> (arr_waddr[ADDR_W-1:PAGE_W] == $past(arr_waddr[ADDR_W-1:PAGE_W]))); // R5
  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$fell(prot_en)); // R8
endmodule

bind pgw_mem_seq pgw_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWC(TWC)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .dq_oe(dq_oe),
  .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr), .prot_en(prot_en)
);

// File: tb/tb_pgw_mem_seq.sv
`timescale 1ns/1ps
module tb_pgw_mem_seq;
  localparam int ADDR_W = 12;
  localparam int PAGE_W = 7;
  localparam int TBLCO  = 40;
  localparam int TWC    = 200;
  localparam int WAITC  = TBLCO + TWC + 30;
  localparam int WAITS  = TBLCO + 10;

  // op: 0 write, 1 read and compare, 2 wait for commit, 3 wait past load window
  localparam int NV = 31;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 4'd7, 12'h105, 8'h3C},  // R7 unprotected first byte opens load
    {2'd0, 4'd5, 12'h10A, 8'h5A},
    {2'd0, 4'd5, 12'h105, 8'h77},  // R5 overwrite of a buffered byte
    {2'd2, 4'd6, 12'h000, 8'h00},
    {2'd1, 4'd5, 12'h105, 8'h77},  // R5
    {2'd1, 4'd6, 12'h10A, 8'h5A},  // R6
    {2'd1, 4'd6, 12'h100, 8'hFF},  // R6 unloaded byte
    {2'd1, 4'd6, 12'h17F, 8'hFF},  // R6 last byte of page
    {2'd0, 4'd2, 12'h555, 8'hAA},  // R2 unlock step 1
    {2'd0, 4'd2, 12'hAAA, 8'h55},
    {2'd0, 4'd2, 12'h555, 8'hA0},
    {2'd0, 4'd5, 12'h200, 8'h11},
    {2'd0, 4'd5, 12'h281, 8'h22},  // R5 last byte picks the page
    {2'd2, 4'd6, 12'h000, 8'h00},
    {2'd1, 4'd5, 12'h280, 8'h11},
    {2'd1, 4'd5, 12'h281, 8'h22},
    {2'd1, 4'd6, 12'h2FF, 8'hFF},
    {2'd0, 4'd8, 12'h105, 8'h00},  // R8 load with no unlock
    {2'd2, 4'd8, 12'h000, 8'h00},
    {2'd1, 4'd8, 12'h105, 8'h77},
    {2'd0, 4'd2, 12'h555, 8'hAA},
    {2'd0, 4'd2, 12'hAAA, 8'h55},
    {2'd0, 4'd2, 12'h555, 8'hA5},  // R2 wrong third byte
    {2'd0, 4'd2, 12'h10A, 8'h00},
    {2'd2, 4'd2, 12'h000, 8'h00},
    {2'd1, 4'd2, 12'h10A, 8'h5A},
    {2'd0, 4'd4, 12'h555, 8'hAA},  // R4 unlock with no byte loaded
    {2'd0, 4'd4, 12'hAAA, 8'h55},
    {2'd0, 4'd4, 12'h555, 8'hA0},
    {2'd3, 4'd4, 12'h000, 8'h00},
    {2'd1, 4'd4, 12'h105, 8'h77}   // R4 no internal write, array visible
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic dq_oe;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  pgw_mem_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TBLCO(TBLCO), .TWC(TWC)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dq_in = d; cs_n = 1'b0; we_n = 1'b0;
    idle(4);
    cs_n = 1'b1; we_n = 1'b1;
    idle(4);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; cs_n = 1'b0; oe_n = 1'b0;
    idle(8);
    d = dq_out; oe = dq_oe;
    cs_n = 1'b1; oe_n = 1'b1;
    idle(6);
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'hAAA, 8'h55);
    wr(12'h555, 8'hA0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R6 watchdog: actual run still going, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    idle(6);
    rst = 1'b0;
    idle(5);
    chk("R1 reset dq_oe", {7'b0, dq_oe}, 8'h00);
    chk("R1 reset dq_out", dq_out, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][25:24])
        2'd0: wr(VEC[i][19:8], VEC[i][7:0]);
        2'd1: begin
          rd(VEC[i][19:8], d, oe);
          chk($sformatf("R%0d vector %0d", VEC[i][23:20], i), d, VEC[i][7:0]);
        end
        2'd2: idle(WAITC);
        default: idle(WAITS);
      endcase
    end

    // R1: output enable gating
    @(negedge clk); addr = 12'h105; cs_n = 1'b0; oe_n = 1'b1; idle(8);
    chk("R1 cs low oe high", {7'b0, dq_oe}, 8'h00);
    cs_n = 1'b1; oe_n = 1'b0; idle(8);
    chk("R1 cs high oe low", {7'b0, dq_oe}, 8'h00);
    cs_n = 1'b0; idle(8);
    chk("R1 both low", {7'b0, dq_oe}, 8'h01);
    chk("R1 both low data", dq_out, 8'h77);
    cs_n = 1'b1; oe_n = 1'b1; idle(6);

    // R3: address at strobe start, data at strobe end
    unlock();
    @(negedge clk);
    addr = 12'h190; dq_in = 8'h00; cs_n = 1'b0; we_n = 1'b0;
    idle(2);
    addr = 12'h1AA; dq_in = 8'h4D;
    idle(2);
    cs_n = 1'b1; we_n = 1'b1;
    idle(4);
    idle(WAITC);
    rd(12'h190, d, oe); chk("R3 start address, end data", d, 8'h4D);
    rd(12'h1AA, d, oe); chk("R3 late address unused", d, 8'hFF);

    // R4: a gap just under the limit keeps the window open
    unlock();
    wr(12'h3A0, 8'h12);
    idle(TBLCO - 15);
    wr(12'h3A1, 8'h34);
    idle(WAITC);
    rd(12'h3A0, d, oe); chk("R4 first byte", d, 8'h12);
    rd(12'h3A1, d, oe); chk("R4 second byte in open window", d, 8'h34);

    // R9: polling status during the internal write
    unlock();
    wr(12'h300, 8'h80);
    idle(TBLCO + 10);
    rd(12'h105, d, oe); chk("R9 first status read", d, 8'h40);
    chk("R9 status drives bus", {7'b0, oe}, 8'h01);
    rd(12'h105, d, oe); chk("R9 second status read", d, 8'h00);
    idle(TWC + 20);
    rd(12'h300, d, oe); chk("R9 array data after write", d, 8'h80);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule